// File: doc/BRIEF.md
# Fuse Map Row Stream Generator

This block turns a linear fuse bitmap into the serial bit order that a programmable-logic device expects during row programming. The bitmap sits in a bit-addressable memory that is read one bit at a time through an address/data port with one cycle of read latency. In that memory the main array is laid out as 132 groups of 44 bits. The device takes 44 rows of 132 bits. The generator reads the memory with a stride of 44, so it does the transpose on the fly and never holds a copy of the whole array.

A requester asks for one array row or for the macrocell configuration area. For an array row the block sends the 132 data bits and then the 6-bit row number, most significant bit first. Row 44 is a spare user row, and its data comes from a 132-bit register input instead of the memory. For the configuration area it sends 20 bits with each adjacent pair exchanged, and no row number follows them. Rows above 44 are refused so that the rows that cannot be undone and the rows that lock read-out are never reached. The result leaves through a valid/ready bit stream towards a serial shift engine.

Top module: `fuse_row_streamer`

## Requirements
- R1: After reset, out_valid and err are low and req_ready is high.
- R2: For an array request with row r in 0..43, stream bit k (k = 0..131, first bit sent is k = 0) is memory bit r + 44*k, so row 0 begins at bit 0 and row 43 ends at bit 5807.
- R3: The 132 data bits are followed by the 6-bit row number, most significant bit first. out_last is high on that sixth address bit only, which makes 138 bits per array stream.
- R4: A request for row 44 takes data bit k from user_row[k] (bit 0 first) and does not read the memory for those bits. The address 44 follows.
- R5: A configuration request (req_cfg = 1) sends 20 bits. Stream bit k is memory bit 5808 + (k XOR 1), so the order is 1,0,3,2,…,19,18. No address follows, and out_last is high on the 20th bit.
- R6: An array request (req_cfg = 0) with row above 44 is accepted but makes no stream bits. err is high for exactly one cycle, in the cycle after acceptance.
- R7: rd_data is taken one cycle after rd_en/rd_addr. While out_ready stays high the stream runs at one bit per cycle with no gaps.
- R8: While out_valid is high and out_ready is low, out_valid, out_bit and out_last hold their values.
- R9: req_ready is low from the cycle after a stream request is accepted until that stream has issued its last read.
- R10: rd_en is only asserted for addresses below 5828, the end of the configuration area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_cfg | input | 1 | 1 selects the configuration area, 0 an array row |
| req_row | input | 6 | Requested row for array requests |
| user_row | input | 132 | Contents of spare user row 44 |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 13 | Memory bit address |
| rd_data | input | 1 | Memory bit, one cycle after rd_en |
| out_valid | output | 1 | Stream bit available |
| out_ready | input | 1 | Consumer takes the bit this cycle |
| out_bit | output | 1 | Stream bit |
| out_last | output | 1 | Final bit of the current stream |
| err | output | 1 | One-cycle pulse for a refused row request |

## Verification
The sequencer returns to idle while the last two or three bits of a stream are still in flight or buffered. A new request can therefore be accepted in the same cycle that earlier stream bits are being handed out. The bench provokes this by firing a refused row request the moment req_ready rises during a backpressured stream. It judges the result two ways: err must pulse in the next cycle, and the tail of the earlier stream must still arrive complete, in order, and with out_last in the right place. Random and alternating ready patterns also make memory returns coincide with stalled outputs, and every bit is compared against the transpose computed with a multiply.

// File: rtl/fuse_stream_pkg.sv
package fuse_stream_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_ADDR = 2'd2,
    S_CFG  = 2'd3
  } seq_state_e;

  // Configuration bits leave in swapped pairs: 1,0,3,2,...
  function automatic int cfg_source(input int base, input int k);
    return base + (k ^ 1);
  endfunction

  // k-th bit of a width-bit value, most significant bit first.
  function automatic logic msb_first_bit(input logic [31:0] val, input int width, input int k);
    return val[width-1-k];
  endfunction

endpackage

// File: rtl/fuse_bit_sequencer.sv
module fuse_bit_sequencer
  import fuse_stream_pkg::*;
#(
  parameter int ROWS     = 44,
  parameter int ROW_BITS = 132,
  parameter int CFG_BITS = 20,
  parameter int ADDR_W   = 6,
  parameter int SRC_AW   = 13,
  parameter int IDX_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_cfg,
  input  logic [ADDR_W-1:0]   req_row,
  output logic                req_ready,
  output logic                err,
  input  logic [ROW_BITS-1:0] user_row,
  input  logic                credit_ok,
  output logic                iss_valid,
  output logic                iss_mem,
  output logic                iss_bit,
  output logic                iss_last,
  output logic [SRC_AW-1:0]   rd_addr
);

  localparam int CFG_BASE = ROWS * ROW_BITS;
  localparam int SRC_BITS = CFG_BASE + CFG_BITS;
  localparam logic [ADDR_W-1:0] USER_ROW_V = ADDR_W'(ROWS);
  localparam logic [IDX_W-1:0]  DATA_LAST  = IDX_W'(ROW_BITS - 1);
  localparam logic [IDX_W-1:0]  ADDR_LAST  = IDX_W'(ADDR_W - 1);
  localparam logic [IDX_W-1:0]  CFG_LAST   = IDX_W'(CFG_BITS - 1);
  localparam logic [SRC_AW-1:0] STRIDE     = SRC_AW'(ROWS);

  seq_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SRC_AW-1:0]   src_q;
  logic [ADDR_W-1:0]   row_q;
  logic                user_sel_q;
  logic                err_q;

  // Named internal events
  logic seq_accept, seq_reject, seq_done;

  assign req_ready  = (state_q == S_IDLE);
  assign seq_accept = req_valid && req_ready;
  assign seq_reject = seq_accept && !req_cfg && (req_row > USER_ROW_V);
  assign iss_valid  = (state_q != S_IDLE) && credit_ok;
  assign seq_done   = iss_valid && iss_last;
  assign err        = err_q;

  always_comb begin
    iss_mem  = 1'b0;
    iss_bit  = 1'b0;
    iss_last = 1'b0;
    rd_addr  = src_q;
    unique case (state_q)
      S_DATA: begin
        iss_mem = !user_sel_q;
        iss_bit = user_row[idx_q];
      end
      S_ADDR: begin
        iss_bit  = msb_first_bit(32'(row_q), ADDR_W, int'(idx_q));
        iss_last = (idx_q == ADDR_LAST);
      end
      S_CFG: begin
        iss_mem  = 1'b1;
        iss_last = (idx_q == CFG_LAST);
        rd_addr  = SRC_AW'(cfg_source(CFG_BASE, int'(idx_q)));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      src_q      <= '0;
      row_q      <= '0;
      user_sel_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= seq_reject;
      unique case (state_q)
        S_IDLE: begin
          if (seq_accept) begin
            idx_q <= '0;
            if (req_cfg) begin
              state_q <= S_CFG;
            end else if (!seq_reject) begin
              state_q    <= S_DATA;
              src_q      <= SRC_AW'(req_row);
              row_q      <= req_row;
              user_sel_q <= (req_row == USER_ROW_V);
            end
          end
        end
        S_DATA: begin
          if (iss_valid) begin
            if (idx_q == DATA_LAST) begin
              state_q <= S_ADDR;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
              src_q <= src_q + STRIDE;
            end
          end
        end
        S_ADDR, S_CFG: begin
          if (iss_valid) begin
            if (iss_last) begin
              state_q <= S_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6: refusal pulse lasts one cycle and starts no stream
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q) else $error("err held longer than one cycle");
  a_r6_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reject |=> (state_q == S_IDLE)) else $error("refused request started a stream");
  // R2: running address advances by the stride per issued array bit
  a_r2_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && state_q == S_DATA && !user_sel_q && idx_q != DATA_LAST)
      |=> (src_q == $past(src_q) + STRIDE)) else $error("stride step wrong");
  // R10: reads stay inside the stored bitmap
  a_r10_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_mem) |-> (int'(rd_addr) < SRC_BITS)) else $error("read past end");
  // R3: the final bit of a stream returns the sequencer to idle
  a_r3_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> req_ready) else $error("not idle after last bit");

endmodule

// File: rtl/fuse_bit_buffer.sv
module fuse_bit_buffer (
  input  logic clk,
  input  logic rst_n,
  input  logic iss_valid,
  input  logic iss_mem,
  input  logic iss_bit,
  input  logic iss_last,
  input  logic rd_data,
  output logic credit_ok,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last
);

  // One read in flight plus two buffered entries keeps one bit per cycle.
  localparam int DEPTH = 2;

  logic       inf_v_q, inf_mem_q, inf_bit_q, inf_last_q;
  logic [1:0] bit_q, last_q;
  logic [1:0] cnt_q;

  // Named internal events
  logic push, pop, push_bit;
  logic [1:0] occupancy;

  assign push      = inf_v_q;
  assign push_bit  = inf_mem_q ? rd_data : inf_bit_q;
  assign pop       = out_valid && out_ready;
  assign out_valid = (cnt_q != 2'd0);
  assign out_bit   = bit_q[0];
  assign out_last  = last_q[0];
  assign occupancy = cnt_q + {1'b0, inf_v_q};
  assign credit_ok = (int'(occupancy) < DEPTH) || ((int'(occupancy) == DEPTH) && pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inf_v_q    <= 1'b0;
      inf_mem_q  <= 1'b0;
      inf_bit_q  <= 1'b0;
      inf_last_q <= 1'b0;
      bit_q      <= '0;
      last_q     <= '0;
      cnt_q      <= '0;
    end else begin
      inf_v_q    <= iss_valid;
      inf_mem_q  <= iss_mem;
      inf_bit_q  <= iss_bit;
      inf_last_q <= iss_last;
      unique case ({push, pop})
        2'b10: begin
          if (cnt_q == 2'd0) begin
            bit_q[0] <= push_bit; last_q[0] <= inf_last_q;
          end else begin
            bit_q[1] <= push_bit; last_q[1] <= inf_last_q;
          end
          cnt_q <= cnt_q + 2'd1;
        end
        2'b01: begin
          bit_q[0] <= bit_q[1]; last_q[0] <= last_q[1];
          cnt_q    <= cnt_q - 2'd1;
        end
        2'b11: begin
          if (cnt_q == 2'd1) begin
            bit_q[0] <= push_bit; last_q[0] <= inf_last_q;
          end else begin
            bit_q[0] <= bit_q[1]; last_q[0] <= last_q[1];
            bit_q[1] <= push_bit; last_q[1] <= inf_last_q;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: a stalled output is held
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)))
    else $error("stalled output changed");
  // R7: the credit scheme never overfills the buffer
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (int'(cnt_q) < DEPTH)) else $error("buffer overflow");
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH) else $error("buffer count out of range");

endmodule

// File: rtl/fuse_row_streamer.sv
module fuse_row_streamer
  import fuse_stream_pkg::*;
#(
  parameter int ROWS     = 44,
  parameter int ROW_BITS = 132,
  parameter int CFG_BITS = 20,
  parameter int ADDR_W   = 6,
  localparam int SRC_BITS = ROWS * ROW_BITS + CFG_BITS,
  localparam int SRC_AW   = $clog2(SRC_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_cfg,
  input  logic [ADDR_W-1:0]   req_row,
  input  logic [ROW_BITS-1:0] user_row,
  output logic                rd_en,
  output logic [SRC_AW-1:0]   rd_addr,
  input  logic                rd_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit,
  output logic                out_last,
  output logic                err
);

  localparam int IDX_MAX = (ROW_BITS > CFG_BITS) ? ROW_BITS : CFG_BITS;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);

  logic credit_ok, iss_valid, iss_mem, iss_bit, iss_last;

  fuse_bit_sequencer #(
    .ROWS(ROWS), .ROW_BITS(ROW_BITS), .CFG_BITS(CFG_BITS),
    .ADDR_W(ADDR_W), .SRC_AW(SRC_AW), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cfg(req_cfg), .req_row(req_row),
    .req_ready(req_ready), .err(err), .user_row(user_row),
    .credit_ok(credit_ok), .iss_valid(iss_valid), .iss_mem(iss_mem),
    .iss_bit(iss_bit), .iss_last(iss_last), .rd_addr(rd_addr)
  );

  assign rd_en = iss_valid && iss_mem;

  fuse_bit_buffer u_buf (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_mem(iss_mem), .iss_bit(iss_bit), .iss_last(iss_last),
    .rd_data(rd_data), .credit_ok(credit_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last)
  );

  // R9: busy generator never advertises readiness
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_cfg || req_row <= ADDR_W'(ROWS))) |=> !req_ready)
    else $error("ready right after a stream request");

endmodule

// File: tb/tb_fuse_row_streamer.sv
module tb_fuse_row_streamer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_cfg = 1'b0, out_ready = 1'b0;
  logic [5:0]   req_row = '0;
  logic [131:0] user_row;
  logic         req_ready, rd_en, rd_data, out_valid, out_bit, out_last, err;
  logic [12:0]  rd_addr;

  int checks = 0, fails = 0, oob = 0, hold_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  fuse_row_streamer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cfg(req_cfg), .req_row(req_row), .user_row(user_row),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last), .err(err)
  );

  function automatic logic mem_bit(input int a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    return h[17] ^ h[5] ^ h[23];
  endfunction

  // Memory model: one cycle of read latency (R7); range watch (R10)
  always @(posedge clk) begin
    rd_data <= mem_bit(int'(rd_addr));
    if (rst_n && rd_en && int'(rd_addr) >= 5828) oob++;
  end

  // R8: a stalled bit must still be there one cycle later
  logic hold_prev = 1'b0, bit_prev = 1'b0, last_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && hold_prev && (!out_valid || out_bit != bit_prev || out_last != last_prev)) hold_bad++;
    hold_prev <= out_valid && !out_ready;
    bit_prev  <= out_bit;
    last_prev <= out_last;
  end

  function automatic logic exp_bit(input logic cfg, input int row, input int k);
    if (cfg) return mem_bit(5808 + ((k % 2 == 0) ? k + 1 : k - 1));
    if (k >= 132) return logic'((row >> (137 - k)) & 1);
    if (row == 44) return user_row[k];
    return mem_bit(row + 44 * k);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_stream(input logic cfg, input int row, input int pat,
                            input bit inject, input string tag);
    int len, n, bad, first, lastc, cyc, bad_k, bad_act, bad_exp;
    bit done, inj_sent, inj_pend, inj_ok;
    len = cfg ? 20 : 138;
    n = 0; bad = 0; first = -1; lastc = 0; cyc = 0; done = 0;
    bad_k = -1; bad_act = 0; bad_exp = 0;
    inj_sent = 0; inj_pend = 0; inj_ok = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cfg = cfg; req_row = 6'(row);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9 busy after accept", int'(req_ready), 0);
    while (!done && cyc < 3000) begin
      if (inj_pend) begin
        req_valid = 1'b0; inj_pend = 0; inj_ok = err && (n < len || !done);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (pat)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0];
        default: out_ready = lfsr[0];
      endcase
      if (inject && !inj_sent && req_ready && n > 0) begin
        req_valid = 1'b1; req_cfg = 1'b0; req_row = 6'd50;
        inj_sent = 1; inj_pend = 1;
      end
      if (out_valid && out_ready) begin
        if (out_bit != exp_bit(cfg, row, n) || out_last != (n == len - 1)) begin
          bad++;
          if (bad_k < 0) begin bad_k = n; bad_act = int'(out_bit); bad_exp = int'(exp_bit(cfg, row, n)); end
        end
        if (first < 0) first = cyc;
        lastc = cyc;
        n++;
        if (out_last) done = 1;
      end
      @(negedge clk);
      cyc++;
    end
    if (inj_pend) begin req_valid = 1'b0; inj_ok = err; end
    out_ready = 1'b0;
    check(n == len, {tag, " stream length"}, n, len);
    check(bad == 0, {tag, " bit order (first bad index in next line if any)"}, bad_act, bad_exp);
    if (bad != 0) $display("  index %0d", bad_k);
    if (pat == 0) check(lastc - first == len - 1, "R7 one bit per cycle", lastc - first, len - 1);
    if (inject) check(inj_sent && inj_ok, "R6 refusal during drain", int'(inj_ok), 1);
  endtask

  task automatic run_reject(input int row);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cfg = 1'b0; req_row = 6'(row);
    @(negedge clk);
    req_valid = 1'b0;
    check(err && !out_valid && req_ready, "R6 err pulse", int'({err, out_valid, req_ready}), 5);
    @(negedge clk);
    check(!err && !out_valid && !rd_en, "R6 err single cycle", int'({err, out_valid}), 0);
  endtask

  // {cfg, row[5:0], pattern[1:0]}; pattern 0 ready high, 1 alternating, 2 random
  localparam logic [8:0] VEC [12] = '{
    {1'b0, 6'd0,  2'd0}, {1'b0, 6'd1,  2'd1}, {1'b0, 6'd17, 2'd2}, {1'b0, 6'd43, 2'd0},
    {1'b0, 6'd43, 2'd2}, {1'b0, 6'd44, 2'd0}, {1'b0, 6'd44, 2'd1}, {1'b1, 6'd0,  2'd0},
    {1'b1, 6'd0,  2'd2}, {1'b0, 6'd30, 2'd1}, {1'b1, 6'd0,  2'd1}, {1'b0, 6'd2,  2'd2}
  };

  initial begin
    for (int i = 0; i < 132; i++) user_row[i] = ((i % 3) == 0) ^ (i > 70) ^ (i == 5);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid && !err && req_ready, "R1 reset state", int'({out_valid, err, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !err && req_ready, "R1 after release", int'({out_valid, err, req_ready}), 1);
    for (int v = 0; v < 12; v++) begin
      string tag;
      if (VEC[v][8]) tag = "R5 config";
      else if (VEC[v][7:2] == 6'd44) tag = "R4 user row";
      else tag = "R2 R3 array row";
      run_stream(VEC[v][8], int'(VEC[v][7:2]), int'(VEC[v][1:0]), 1'b0, tag);
    end
    // R6: boundary refusals
    run_reject(45);
    run_reject(63);
    // R6 with a stream tail still draining
    run_stream(1'b0, 9, 2, 1'b1, "R2 R3 drain");
    run_stream(1'b1, 0, 1, 1'b1, "R5 drain");
    check(oob == 0, "R10 read range", oob, 0);
    check(hold_bad == 0, "R8 stall hold", hold_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule